// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank graphics DDR SDRAM. It takes the memory from reset to a usable state by driving the clock enable, the four command strobes, the row/column address bus and the bank-select bus through a fixed bring-up program. First it holds the clock enable low while the clock settles. It then wakes the device and closes every bank. Next it enables the on-die delay-locked loop through the extended register and resets that loop through the main register. It closes all banks a second time, runs a programmable number of auto-refresh cycles, and finally loads the operating mode.

Every minimum spacing is given in nanoseconds or clocks through parameters. Each one is turned into whole clock cycles at elaboration, always rounding up. The loop-lock interval is timed by its own counter, which runs while the precharge and refresh steps proceed, so the final mode load waits only for whichever of the two finishes later. A done flag rises once the last register write has settled, and it stays high. After that the sequencer idles with no-operation commands, and normal traffic can be handed to the main controller.

Top module: `gddr_init_seq`

## Requirements
- R1: While reset is held, and for ceil(STABLE_NS*1000/CLK_PS) cycles after its release (cycle 0 is the cycle in which reset falls), `cke` is low, the pins show NOP (`cs_n`=0, `ras_n`/`cas_n`/`we_n`=1) and `init_done` is low.
- R2: In the first cycle after the stable wait, `cke` rises with a NOP on the pins. The next cycle carries precharge-all: `ras_n`=0, `cas_n`=1, `we_n`=0, address bit 8 high, every other address bit and `ba` zero.
- R3: The extended register write (all four strobes low, `ba`=01) comes max(2, ceil(TRP_NS)) cycles after the first precharge. Address bit 0 is 0 (loop enabled), the drive code sits with its high bit on address bit 6 and its low bit on address bit 1 (00 full, 01 weak, 11 matched), and all other address bits are zero.
- R4: The main register write with loop reset (`ba`=00, address bit 8 high) comes max(EMRS_GAP_CYC, MRD_CYC, 2) cycles after the extended write.
- R5: The second precharge-all comes max(2, MRD_CYC) cycles after the loop-reset write, and the first auto-refresh (`ras_n`=0, `cas_n`=0, `we_n`=1, address and `ba` zero) comes the precharge gap after it.
- R6: Exactly REFRESH_COUNT auto-refresh commands are issued, each one max(2, ceil(TRFC_NS)) cycles after the one before.
- R7: The final mode write comes in the later of two cycles: the refresh gap after the last refresh, or DLL_LOCK_CYC cycles after the loop-reset write.
- R8: In both main register writes, address bits 2:0 hold the burst code (001 = 2, 010 = 4, 011 = 8), bit 3 holds the burst type (0 sequential, 1 interleave), bits 6:4 hold the latency in binary (3 to 6), and bit 7, bits 11:9 and `ba` are zero. Bit 8 is 1 in the loop-reset write and 0 in the final write.
- R9: Every cycle that carries no command from the program above is a NOP, and once `cke` has risen it stays high.
- R10: `init_done` rises max(2, MRD_CYC) cycles after the final mode write and then stays high, with only NOPs on the pins.
- R11: The drive code 10 never appears in the extended write, and no reserved burst or latency code ever appears in a main register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | 12 | Multiplexed address / register data |
| ba | output | 2 | Bank select; 01 picks the extended register |
| init_done | output | 1 | High once the bring-up program is complete |

## Verification
Two things can come due in the same cycle: the loop-lock counter reaching its limit and the last refresh gap ending. The test builds two instances. In the first, the lock interval clearly outlasts the refresh chain, so the final mode write has to wait for the lock counter. In the second, the lock length is chosen so that both conditions fall in the very same cycle. That instance also uses other timings, an exact-multiple rounding case, three refreshes and different mode fields. In both cases the scoreboard expects the final write in the cycle right after the later condition, and any cycle of early issue or extra stall is reported.

// File: rtl/gddr_init_pkg.sv
`timescale 1ns/1ps
package gddr_init_pkg;

    localparam int ADDR_W = 12;
    localparam int BA_W   = 2;
    localparam int AP_BIT = 8;   // all-bank select on precharge, loop reset on mode load

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRECHARGE_ALL,
        CMD_REFRESH,
        CMD_LOAD_MODE
    } cmd_e;

    typedef enum logic [2:0] {
        ST_STABLE,
        ST_WAKE,
        ST_ISSUE,
        ST_GAP,
        ST_LOCK,
        ST_DONE
    } state_e;

    typedef enum logic [2:0] {
        STEP_PRE1,
        STEP_EMRS,
        STEP_MRS_DLL,
        STEP_PRE2,
        STEP_REF,
        STEP_MRS_FINAL
    } step_e;

    typedef struct packed {
        cmd_e              cmd;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
    } cmd_word_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned clk_ps);
        return (ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [2:0] burst_code(int unsigned bl);
        case (bl)
            2:       return 3'b001;
            4:       return 3'b010;
            8:       return 3'b011;
            default: return 3'b000;
        endcase
    endfunction

    function automatic cmd_word_t idle_word();
        cmd_word_t w;
        w = '0;
        w.cmd = CMD_NOP;
        return w;
    endfunction

    function automatic cmd_word_t precharge_word();
        cmd_word_t w;
        w = '0;
        w.cmd = CMD_PRECHARGE_ALL;
        w.addr[AP_BIT] = 1'b1;
        return w;
    endfunction

    function automatic cmd_word_t refresh_word();
        cmd_word_t w;
        w = '0;
        w.cmd = CMD_REFRESH;
        return w;
    endfunction

    function automatic cmd_word_t ext_word(logic [1:0] drive);
        cmd_word_t w;
        w = '0;
        w.cmd     = CMD_LOAD_MODE;
        w.ba      = 2'b01;
        w.addr[1] = drive[0];
        w.addr[6] = drive[1];
        return w;
    endfunction

    function automatic cmd_word_t mode_word(int unsigned cl, int unsigned bl,
                                            logic interleave, logic dll_rst);
        cmd_word_t w;
        w = '0;
        w.cmd          = CMD_LOAD_MODE;
        w.addr[2:0]    = burst_code(bl);
        w.addr[3]      = interleave;
        w.addr[6:4]    = 3'(cl);
        w.addr[AP_BIT] = dll_rst;
        return w;
    endfunction

    function automatic pins_t encode(cmd_e c);
        case (c)
            CMD_PRECHARGE_ALL: return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_REFRESH:       return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            CMD_LOAD_MODE:     return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            default:           return '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
    endfunction

endpackage

// File: rtl/gddr_gap_timer.sv
`timescale 1ns/1ps
module gddr_gap_timer #(
    parameter int          W       = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= W'(RST_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/gddr_cmd_encoder.sv
`timescale 1ns/1ps
module gddr_cmd_encoder
    import gddr_init_pkg::*;
(
    input  cmd_word_t         req,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);
    pins_t p;

    always_comb begin
        p     = encode(req.cmd);
        cs_n  = p.cs_n;
        ras_n = p.ras_n;
        cas_n = p.cas_n;
        we_n  = p.we_n;
        addr  = req.addr;
        ba    = req.ba;
    end
endmodule

// File: rtl/gddr_init_fsm.sv
`timescale 1ns/1ps
module gddr_init_fsm
    import gddr_init_pkg::*;
#(
    parameter int unsigned TRP_G         = 6,
    parameter int unsigned TRFC_G        = 20,
    parameter int unsigned MRD_G         = 4,
    parameter int unsigned EMRS_G        = 20,
    parameter int unsigned LOCK_CYC      = 200,
    parameter int unsigned REFRESH_COUNT = 2,
    parameter int unsigned CAS_LAT       = 5,
    parameter int unsigned BURST_LEN     = 4,
    parameter bit          INTERLEAVE    = 1'b0,
    parameter logic [1:0]  DRIVE_CODE    = 2'b00,
    parameter int          CNT_W         = 8,
    parameter int          LOCK_W        = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gap_expired,
    input  logic              lock_expired,
    output logic              gap_load,
    output logic [CNT_W-1:0]  gap_val,
    output logic              lock_load,
    output logic [LOCK_W-1:0] lock_val,
    output logic              cke,
    output logic              init_done,
    output cmd_word_t         req
);
    localparam int REF_W = $clog2(REFRESH_COUNT + 1);

    state_e           state_q, state_d;
    step_e            step_q, step_d;
    logic [REF_W-1:0] ref_q, ref_d;
    int unsigned      step_gap;
    cmd_word_t        step_word;

    always_comb begin
        case (step_q)
            STEP_PRE1, STEP_PRE2: begin
                step_gap  = TRP_G;
                step_word = precharge_word();
            end
            STEP_EMRS: begin
                step_gap  = EMRS_G;
                step_word = ext_word(DRIVE_CODE);
            end
            STEP_MRS_DLL: begin
                step_gap  = MRD_G;
                step_word = mode_word(CAS_LAT, BURST_LEN, INTERLEAVE, 1'b1);
            end
            STEP_MRS_FINAL: begin
                step_gap  = MRD_G;
                step_word = mode_word(CAS_LAT, BURST_LEN, INTERLEAVE, 1'b0);
            end
            default: begin
                step_gap  = TRFC_G;
                step_word = refresh_word();
            end
        endcase
    end

    always_comb begin
        state_d   = state_q;
        step_d    = step_q;
        ref_d     = ref_q;
        gap_load  = 1'b0;
        lock_load = 1'b0;
        req       = idle_word();
        case (state_q)
            ST_STABLE: if (gap_expired) state_d = ST_WAKE;
            ST_WAKE:   state_d = ST_ISSUE;
            ST_ISSUE: begin
                req      = step_word;
                gap_load = 1'b1;
                state_d  = ST_GAP;
                if (step_q == STEP_MRS_DLL) lock_load = 1'b1;
                if (step_q == STEP_REF)     ref_d = ref_q + 1'b1;
            end
            ST_GAP: if (gap_expired) begin
                state_d = ST_ISSUE;
                case (step_q)
                    STEP_PRE1:    step_d = STEP_EMRS;
                    STEP_EMRS:    step_d = STEP_MRS_DLL;
                    STEP_MRS_DLL: step_d = STEP_PRE2;
                    STEP_PRE2:    step_d = STEP_REF;
                    STEP_REF: if (ref_q >= REF_W'(REFRESH_COUNT)) begin
                        step_d  = STEP_MRS_FINAL;
                        state_d = lock_expired ? ST_ISSUE : ST_LOCK;
                    end
                    default:      state_d = ST_DONE;
                endcase
            end
            ST_LOCK: if (lock_expired) state_d = ST_ISSUE;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_STABLE;
            step_q  <= STEP_PRE1;
            ref_q   <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            ref_q   <= ref_d;
        end
    end

    assign gap_val   = CNT_W'(step_gap - 2);
    assign lock_val  = LOCK_W'(LOCK_CYC - 2);
    assign cke       = (state_q != ST_STABLE);
    assign init_done = (state_q == ST_DONE);
endmodule

// File: rtl/gddr_init_seq.sv
`timescale 1ns/1ps
module gddr_init_seq
    import gddr_init_pkg::*;
#(
    parameter int unsigned CLK_PS           = 2500,
    parameter int unsigned STABLE_NS        = 200000,
    parameter int unsigned TRP_NS           = 15,
    parameter int unsigned TRFC_NS          = 50,
    parameter int unsigned MRD_CYC          = 4,
    parameter int unsigned EMRS_GAP_CYC     = 20,
    parameter int unsigned DLL_LOCK_CYC     = 200,
    parameter int unsigned REFRESH_COUNT    = 2,
    parameter int unsigned CAS_LAT          = 5,
    parameter int unsigned BURST_LEN        = 4,
    parameter bit          BURST_INTERLEAVE = 1'b0,
    parameter logic [1:0]  DRIVE_CODE       = 2'b00
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              init_done
);
    localparam int unsigned STABLE_CYC = max2(1, ns_to_cycles(STABLE_NS, CLK_PS));
    localparam int unsigned TRP_G      = max2(2, ns_to_cycles(TRP_NS, CLK_PS));
    localparam int unsigned TRFC_G     = max2(2, ns_to_cycles(TRFC_NS, CLK_PS));
    localparam int unsigned MRD_G      = max2(2, MRD_CYC);
    localparam int unsigned EMRS_G     = max2(EMRS_GAP_CYC, MRD_G);
    localparam int unsigned LOCK_G     = max2(2, DLL_LOCK_CYC);
    localparam int unsigned CNT_MAX    = max2(STABLE_CYC, max2(max2(TRP_G, TRFC_G), EMRS_G));
    localparam int          CNT_W      = $clog2(CNT_MAX + 1);
    localparam int          LOCK_W     = $clog2(LOCK_G + 1);

    logic              gap_load, gap_expired, lock_load, lock_expired;
    logic [CNT_W-1:0]  gap_val;
    logic [LOCK_W-1:0] lock_val;
    cmd_word_t         req;

    gddr_init_fsm #(
        .TRP_G(TRP_G), .TRFC_G(TRFC_G), .MRD_G(MRD_G), .EMRS_G(EMRS_G),
        .LOCK_CYC(LOCK_G), .REFRESH_COUNT(REFRESH_COUNT), .CAS_LAT(CAS_LAT),
        .BURST_LEN(BURST_LEN), .INTERLEAVE(BURST_INTERLEAVE),
        .DRIVE_CODE(DRIVE_CODE), .CNT_W(CNT_W), .LOCK_W(LOCK_W)
    ) u_fsm (
        .clk(clk), .rst(rst), .gap_expired(gap_expired), .lock_expired(lock_expired),
        .gap_load(gap_load), .gap_val(gap_val), .lock_load(lock_load),
        .lock_val(lock_val), .cke(cke), .init_done(init_done), .req(req)
    );

    gddr_gap_timer #(.W(CNT_W), .RST_VAL(STABLE_CYC - 1)) u_gap_timer (
        .clk(clk), .rst(rst), .load(gap_load), .load_val(gap_val), .expired(gap_expired)
    );

    gddr_gap_timer #(.W(LOCK_W), .RST_VAL(0)) u_lock_timer (
        .clk(clk), .rst(rst), .load(lock_load), .load_val(lock_val), .expired(lock_expired)
    );

    gddr_cmd_encoder u_enc (
        .req(req), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .ba(ba)
    );
endmodule

// File: rtl/gddr_init_checker.sv
`timescale 1ns/1ps
module gddr_init_checker
    import gddr_init_pkg::*;
#(
    parameter int unsigned CLK_PS       = 2500,
    parameter int unsigned TRP_NS       = 15,
    parameter int unsigned TRFC_NS      = 50,
    parameter int unsigned MRD_CYC      = 4,
    parameter int unsigned DLL_LOCK_CYC = 200
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [BA_W-1:0]   ba,
    input logic              init_done
);
    localparam int unsigned TRP_C  = ns_to_cycles(TRP_NS, CLK_PS);
    localparam int unsigned TRFC_C = ns_to_cycles(TRFC_NS, CLK_PS);

    logic        is_nop, is_cmd, is_pre, is_ref, is_load, is_ext, is_mrs, is_final;
    cmd_e        last_q;
    logic [15:0] since_q, since_dll_q;
    logic        dll_seen_q;

    assign is_nop   = !cs_n && ras_n && cas_n && we_n;
    assign is_cmd   = !is_nop;
    assign is_pre   = !cs_n && !ras_n && cas_n && !we_n;
    assign is_ref   = !cs_n && !ras_n && !cas_n && we_n;
    assign is_load  = !cs_n && !ras_n && !cas_n && !we_n;
    assign is_ext   = is_load && ba == 2'b01;
    assign is_mrs   = is_load && ba == 2'b00;
    assign is_final = is_mrs && !addr[AP_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q      <= CMD_NOP;
            since_q     <= '0;
            since_dll_q <= '0;
            dll_seen_q  <= 1'b0;
        end else begin
            if (is_cmd) begin
                since_q <= 16'd1;
                last_q  <= is_pre ? CMD_PRECHARGE_ALL : is_ref ? CMD_REFRESH :
                           is_load ? CMD_LOAD_MODE : CMD_NOP;
            end else if (since_q != 16'hFFFF) begin
                since_q <= since_q + 1'b1;
            end
            if (is_mrs && addr[AP_BIT]) begin
                since_dll_q <= 16'd1;
                dll_seen_q  <= 1'b1;
            end else if (since_dll_q != 16'hFFFF) begin
                since_dll_q <= since_dll_q + 1'b1;
            end
        end
    end

    p_cke_low_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (is_nop && !init_done));

    p_trp_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && last_q == CMD_PRECHARGE_ALL) |-> since_q >= 16'(TRP_C));

    p_trfc_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && last_q == CMD_REFRESH) |-> since_q >= 16'(TRFC_C));

    p_mrd_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && last_q == CMD_LOAD_MODE) |-> since_q >= 16'(MRD_CYC));

    p_dll_lock_r7: assert property (@(posedge clk) disable iff (rst)
        is_final |-> (dll_seen_q && since_dll_q >= 16'(DLL_LOCK_CYC)));

    p_mode_fields_r8: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> (addr[2:0] inside {3'b001, 3'b010, 3'b011} &&
                    addr[6:4] inside {3'd3, 3'd4, 3'd5, 3'd6} &&
                    !addr[7] && addr[11:9] == 3'b000));

    p_drive_legal_r11: assert property (@(posedge clk) disable iff (rst)
        is_ext |-> ({addr[6], addr[1]} != 2'b10 && !addr[0]));

    p_cke_hold_r9: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        init_done |-> is_nop);
endmodule

bind gddr_init_seq gddr_init_checker #(
    .CLK_PS(CLK_PS), .TRP_NS(TRP_NS), .TRFC_NS(TRFC_NS),
    .MRD_CYC(MRD_CYC), .DLL_LOCK_CYC(DLL_LOCK_CYC)
) u_init_checker (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .ba(ba), .init_done(init_done)
);

// File: tb/gddr_init_seq_tb.sv
`timescale 1ns/1ps
module gddr_init_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    // instance A: lock interval dominates the refresh chain
    localparam int A_CLK_PS = 2500, A_STABLE = 1000, A_TRP = 15, A_TRFC = 50;
    localparam int A_MRD = 4, A_EGAP = 20, A_LOCK = 200, A_NREF = 2;
    localparam int A_CL = 5, A_BL = 4, A_BT = 0;
    localparam logic [1:0] A_DRV = 2'b11;
    // instance B: lock expiry and end of last refresh gap in the same cycle
    localparam int B_CLK_PS = 3300, B_STABLE = 990, B_TRP = 15, B_TRFC = 50;
    localparam int B_MRD = 3, B_EGAP = 20, B_LOCK = 56, B_NREF = 3;
    localparam int B_CL = 3, B_BL = 8, B_BT = 1;
    localparam logic [1:0] B_DRV = 2'b01;

    typedef struct {
        int          cyc;
        logic [2:0]  pins;
        logic [1:0]  ba;
        logic [11:0] addr;
        string       req;
    } exp_t;

    exp_t q_a[$];
    exp_t q_b[$];

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_cke, a_cs_n, a_ras_n, a_cas_n, a_we_n, a_done;
    logic b_cke, b_cs_n, b_ras_n, b_cas_n, b_we_n, b_done;
    logic [11:0] a_addr, b_addr;
    logic [1:0]  a_ba, b_ba;

    int checks = 0;
    int errors = 0;
    int cyc_a = 0, cyc_b = 0;
    int s_a, s_b, done_a, done_b;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gddr_init_seq #(
        .CLK_PS(A_CLK_PS), .STABLE_NS(A_STABLE), .TRP_NS(A_TRP), .TRFC_NS(A_TRFC),
        .MRD_CYC(A_MRD), .EMRS_GAP_CYC(A_EGAP), .DLL_LOCK_CYC(A_LOCK),
        .REFRESH_COUNT(A_NREF), .CAS_LAT(A_CL), .BURST_LEN(A_BL),
        .BURST_INTERLEAVE(1'(A_BT)), .DRIVE_CODE(A_DRV)
    ) dut_i (
        .clk(clk), .rst(rst), .cke(a_cke), .cs_n(a_cs_n), .ras_n(a_ras_n),
        .cas_n(a_cas_n), .we_n(a_we_n), .addr(a_addr), .ba(a_ba), .init_done(a_done)
    );

    gddr_init_seq #(
        .CLK_PS(B_CLK_PS), .STABLE_NS(B_STABLE), .TRP_NS(B_TRP), .TRFC_NS(B_TRFC),
        .MRD_CYC(B_MRD), .EMRS_GAP_CYC(B_EGAP), .DLL_LOCK_CYC(B_LOCK),
        .REFRESH_COUNT(B_NREF), .CAS_LAT(B_CL), .BURST_LEN(B_BL),
        .BURST_INTERLEAVE(1'(B_BT)), .DRIVE_CODE(B_DRV)
    ) dut_b (
        .clk(clk), .rst(rst), .cke(b_cke), .cs_n(b_cs_n), .ras_n(b_ras_n),
        .cas_n(b_cas_n), .we_n(b_we_n), .addr(b_addr), .ba(b_ba), .init_done(b_done)
    );

    function automatic int up_cycles(int ns, int clk_ps);
        int c = (ns * 1000) / clk_ps;
        if (c * clk_ps < ns * 1000) c = c + 1;
        return c;
    endfunction

    function automatic int bigger(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int which, input int cyc, input logic [2:0] pins,
                        input logic [1:0] ba, input logic [11:0] addr, input string req);
        exp_t e;
        e.cyc = cyc; e.pins = pins; e.ba = ba; e.addr = addr; e.req = req;
        if (which == 0) q_a.push_back(e); else q_b.push_back(e);
    endtask

    // driver: derive the command schedule from the requirements and queue it
    task automatic plan(input int which, input int clk_ps, input int stable_ns,
                        input int trp_ns, input int trfc_ns, input int mrd, input int egap,
                        input int lock, input int nref, input int cl, input int bl,
                        input int bt, input logic [1:0] drv,
                        output int s_cyc, output int done_cyc);
        int trp = bigger(2, up_cycles(trp_ns, clk_ps));
        int trfc = bigger(2, up_cycles(trfc_ns, clk_ps));
        int mg = bigger(2, mrd);
        int t, t_dll, t_fin;
        logic [11:0] mode = 12'((cl << 4) | (bt << 3) | $clog2(bl));
        s_cyc = up_cycles(stable_ns, clk_ps);
        t = s_cyc + 1;
        push(which, t, 3'b010, 2'b00, 12'h100, "R2");
        t = t + trp;
        push(which, t, 3'b000, 2'b01, 12'((drv[1] << 6) | (drv[0] << 1)), "R3");
        t = t + bigger(egap, mg);
        push(which, t, 3'b000, 2'b00, mode | 12'h100, "R4");
        t_dll = t;
        t = t + mg;
        push(which, t, 3'b010, 2'b00, 12'h100, "R5");
        t = t + trp;
        for (int k = 0; k < nref; k++) begin
            push(which, t, 3'b001, 2'b00, 12'h000, (k == 0) ? "R5" : "R6");
            t = t + trfc;
        end
        t_fin = bigger(t, t_dll + lock);
        push(which, t_fin, 3'b000, 2'b00, mode, "R7");
        done_cyc = t_fin + mg;
    endtask

    // monitor: compare each observed cycle against the queued schedule
    task automatic observe(input int which, input int cyc, input logic cke,
                           input logic cs_n, input logic ras_n, input logic cas_n,
                           input logic we_n, input logic [1:0] ba,
                           input logic [11:0] addr, input logic done);
        int s = (which == 0) ? s_a : s_b;
        int d = (which == 0) ? done_a : done_b;
        bit nop = !cs_n && ras_n && cas_n && we_n;
        exp_t e;
        bit have;
        check(cke == (cyc >= s), (cyc < s) ? "R1" : "R9", $sformatf("cke inst%0d cyc%0d", which, cyc),
              cke, (cyc >= s));
        check(done == (cyc >= d), "R10", $sformatf("init_done inst%0d cyc%0d", which, cyc),
              done, (cyc >= d));
        if (!nop) begin
            have = 1'b0;
            if (which == 0) begin
                if (q_a.size() != 0) begin e = q_a.pop_front(); have = 1'b1; end
            end else begin
                if (q_b.size() != 0) begin e = q_b.pop_front(); have = 1'b1; end
            end
            if (!have) begin
                check(1'b0, "R9", $sformatf("unexpected command inst%0d cyc%0d", which, cyc),
                      {cs_n, ras_n, cas_n, we_n}, 4'b0111);
            end else begin
                check(cyc == e.cyc, e.req, $sformatf("command cycle inst%0d", which), cyc, e.cyc);
                check(!cs_n && {ras_n, cas_n, we_n} == e.pins, e.req,
                      $sformatf("strobes inst%0d cyc%0d", which, cyc),
                      {cs_n, ras_n, cas_n, we_n}, {1'b0, e.pins});
                check(ba == e.ba, e.req, $sformatf("bank inst%0d cyc%0d", which, cyc), ba, e.ba);
                check(addr == e.addr, (e.req == "R7") ? "R8" : e.req,
                      $sformatf("address inst%0d cyc%0d", which, cyc), addr, e.addr);
            end
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (rst) begin
            cyc_a = 0;
            cyc_b = 0;
        end else if (!finished) begin
            cyc_a++;
            cyc_b++;
            observe(0, cyc_a, a_cke, a_cs_n, a_ras_n, a_cas_n, a_we_n, a_ba, a_addr, a_done);
            observe(1, cyc_b, b_cke, b_cs_n, b_ras_n, b_cas_n, b_we_n, b_ba, b_addr, b_done);
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        plan(0, A_CLK_PS, A_STABLE, A_TRP, A_TRFC, A_MRD, A_EGAP, A_LOCK, A_NREF,
             A_CL, A_BL, A_BT, A_DRV, s_a, done_a);
        plan(1, B_CLK_PS, B_STABLE, B_TRP, B_TRFC, B_MRD, B_EGAP, B_LOCK, B_NREF,
             B_CL, B_BL, B_BT, B_DRV, s_b, done_b);
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(!a_cke && !b_cke, "R1", "cke under reset", {a_cke, b_cke}, 0);
        check(!a_done && !b_done, "R1", "init_done under reset", {a_done, b_done}, 0);
        check(!a_cs_n && a_ras_n && a_cas_n && a_we_n, "R1", "NOP under reset",
              {a_cs_n, a_ras_n, a_cas_n, a_we_n}, 4'b0111);
        @(negedge clk);
        rst = 1'b0;
        repeat (bigger(done_a, done_b) + 40) @(posedge clk);
        #2;
        check(q_a.size() == 0, "R6", "commands left unissued inst0", q_a.size(), 0);
        check(q_b.size() == 0, "R6", "commands left unissued inst1", q_b.size(), 0);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", 0, 1);
        summary();
    end
endmodule